// File: doc/BRIEF.md
# Processor Bus-State Tracker with Transceiver Guard

This block sits beside a 16-bit embedded processor whose bus is timed from a double-rate clock (`clk2`). It turns a power-good level into a processor reset that is aligned to `clk2`. The same reset fixes which `clk2` edge ends a processor clock. From then on the block divides `clk2` by two and follows every bus cycle through the idle, address, data and pipelined states.

From the tracked state the block drives a disable for the data-bus transceivers that sit between the processor and slower peripherals. Once a data phase has ended, the buffers stay off through every following idle or address state. A peripheral that still drives read data therefore cannot collide with the processor when the next cycle is a write.

The block also decodes shutdown cycles from the bus status lines and raises a non-maskable interrupt request. The request stays asserted until the upper boot-memory chip select is seen active, which happens when the handler fetches code.

Top module: `bus_phase_tracker`

## Requirements
- R1: `cpu_reset` is high on the clock edge after the synchronized power-good level is low. After `pwr_good` rises, `cpu_reset` falls on exactly the (HOLD_CYCLES+2)-th rising `clk2` edge, counting the first edge that sees `pwr_good` high. It changes only on rising `clk2` edges.
- R2: While `cpu_reset` is high, `phase2` is 1. After reset it toggles on every `clk2` edge. Bus inputs (`ads_n`, `na_n`, `rdy_n`, the status lines, `a1`, `ucs_n`) are sampled only on edges where `phase2` is 1. Values present on other edges have no effect on `bus_state` or `nmi`.
- R3: `bus_state` encodes idle=0, T1=1, T2=2, T1P=3, T2P=4. Idle with `ads_n` low goes to T1. T1 and T1P always go to T2.
- R4: In T2, `rdy_n` low ends the cycle and returns the tracker to idle, unless a pipelined address is issued (R5).
- R5: `na_n` low is recorded when it is sampled in T1, T1P or T2. The record is cleared when a cycle ends. In T2 with the record set, `ads_n` low goes to T2P if `rdy_n` is high, or to T1P if `rdy_n` is low. T2P stays until `rdy_n` is low, then goes to T1P.
- R6: `ads_n` low has no effect on `bus_state` in T1, T1P and T2P, or in T2 when no `na_n` was recorded.
- R7: `xcvr_off` is 1 in idle, T1 and T1P once any T2 or T2P has occurred since reset. It is 0 in T2 and T2P, and 0 before the first data phase.
- R8: A sampled `ads_n` low with status `mio`=1, `dc`=0, `wr`=1 and `a1`=0 (shutdown) sets `nmi` on that edge. The same status with `a1`=1 (halt) does not set it.
- R9: `nmi` is cleared when `ucs_n` is sampled low. A shutdown sampled on the same edge takes priority, so `nmi` stays 1.
- R10: A fall of `pwr_good` at any time reasserts `cpu_reset` and returns the block to idle, with `nmi` and `xcvr_off` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2 | input | 1 | Double-rate bus clock |
| pwr_good | input | 1 | Asynchronous power-good level |
| ads_n | input | 1 | Address strobe, active low |
| na_n | input | 1 | Next-address request, active low |
| rdy_n | input | 1 | Cycle-ready, active low |
| mio | input | 1 | Status: memory (1) or I/O (0) |
| dc | input | 1 | Status: data (1) or control (0) |
| wr | input | 1 | Status: write (1) or read (0) |
| a1 | input | 1 | Address bit 1, separates halt from shutdown |
| ucs_n | input | 1 | Upper boot-memory chip select, active low |
| cpu_reset | output | 1 | Processor reset aligned to clk2 |
| phase2 | output | 1 | High when the next clk2 edge ends a processor clock |
| bus_state | output | 3 | Tracked bus state |
| xcvr_off | output | 1 | Data-transceiver disable |
| nmi | output | 1 | Shutdown interrupt request |

## Verification
Directed cycles show the four kinds of bus cycle apart: a plain read, a cycle stretched by wait states, a cycle where a pipelined address goes to T2P, and one where it goes straight to T1P. Strobes that arrive in the wrong state show that they are ignored.

Between sample edges the bench drives every bus input to its active value, so any sampling on the wrong phase shows up as a state or `nmi` change. A long pseudo-random sweep of strobes, status codes and chip selects is checked step by step against an arithmetic state model. This sweep covers shutdown against halt, and a shutdown that collides with a clear. The reset count is measured at power-up, and again after a power-good drop in the middle of a cycle.

// File: rtl/bus_phase_tracker.sv
module bus_phase_tracker #(
  parameter int HOLD_CYCLES = 16
) (
  input  logic       clk2,
  input  logic       pwr_good,
  input  logic       ads_n,
  input  logic       na_n,
  input  logic       rdy_n,
  input  logic       mio,
  input  logic       dc,
  input  logic       wr,
  input  logic       a1,
  input  logic       ucs_n,
  output logic       cpu_reset,
  output logic       phase2,
  output logic [2:0] bus_state,
  output logic       xcvr_off,
  output logic       nmi
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  typedef enum logic [2:0] {TI = 3'd0, T1 = 3'd1, T2 = 3'd2, T1P = 3'd3, T2P = 3'd4} bst_t;

  logic pg_s1, pg_s2, rst_q, ph, na_seen, dp_seen, nmi_q;
  logic [CW-1:0] hold_cnt;
  bst_t st, st_nxt;

  always_ff @(posedge clk2 or negedge pwr_good)
    if (!pwr_good) begin
      pg_s1 <= 1'b0;
      pg_s2 <= 1'b0;
    end else begin
      pg_s1 <= 1'b1;
      pg_s2 <= pg_s1;
    end

  always_ff @(posedge clk2)
    if (!pg_s2) begin
      hold_cnt <= '0;
      rst_q    <= 1'b1;
    end else if (hold_cnt != LAST) hold_cnt <= hold_cnt + 1'b1;
    else rst_q <= 1'b0;

  always_ff @(posedge clk2)
    if (rst_q) ph <= 1'b1;
    else ph <= ~ph;

  wire sample   = ph & ~rst_q;
  wire ads      = ~ads_n;
  wire rdy      = ~rdy_n;
  wire pipe_ads = ads & na_seen;
  wire shutdown = ads & mio & ~dc & wr & ~a1;

  always_comb begin
    st_nxt = st;
    case (st)
      TI:      if (ads) st_nxt = T1;
      T1, T1P: st_nxt = T2;
      T2:      if (rdy) st_nxt = pipe_ads ? T1P : TI;
               else if (pipe_ads) st_nxt = T2P;
      T2P:     if (rdy) st_nxt = T1P;
      default: st_nxt = TI;
    endcase
  end

  always_ff @(posedge clk2)
    if (rst_q) begin
      st      <= TI;
      na_seen <= 1'b0;
      nmi_q   <= 1'b0;
    end else if (sample) begin
      st      <= st_nxt;
      na_seen <= (st_nxt == T2) & (((st == T2) & na_seen) | ~na_n);
      if (shutdown) nmi_q <= 1'b1;
      else if (!ucs_n) nmi_q <= 1'b0;
    end

  always_ff @(posedge clk2)
    if (rst_q) dp_seen <= 1'b0;
    else if (st == T2 || st == T2P) dp_seen <= 1'b1;

  assign cpu_reset = rst_q;
  assign phase2    = ph;
  assign bus_state = st;
  assign nmi       = nmi_q;
  assign xcvr_off  = dp_seen & (st == TI || st == T1 || st == T1P);

  assert_reset_follows_pg_R1: assert property (@(posedge clk2) !pg_s2 |=> cpu_reset);
  assert_no_change_off_phase_R2: assert property (@(posedge clk2) disable iff (rst_q)
    !ph |=> $stable(bus_state));
  assert_t1_leads_to_t2_R3: assert property (@(posedge clk2) disable iff (rst_q)
    (ph && (bus_state == 3'd1 || bus_state == 3'd3)) |=> bus_state == 3'd2);
  assert_ready_ends_cycle_R4: assert property (@(posedge clk2) disable iff (rst_q)
    (ph && bus_state == 3'd2 && !rdy_n && ads_n) |=> bus_state == 3'd0);
  assert_pipe_done_R5: assert property (@(posedge clk2) disable iff (rst_q)
    (ph && bus_state == 3'd4 && !rdy_n) |=> bus_state == 3'd3);
  assert_guard_after_data_R7: assert property (@(posedge clk2) disable iff (rst_q)
    (ph && bus_state == 3'd2 && !rdy_n) |=> xcvr_off);
  assert_shutdown_sets_nmi_R8: assert property (@(posedge clk2) disable iff (rst_q)
    (ph && !ads_n && mio && !dc && wr && !a1) |=> nmi);
  assert_nmi_holds_off_phase_R9: assert property (@(posedge clk2) disable iff (rst_q)
    (!ph && nmi) |=> nmi);
endmodule

// File: tb/sim_bus_phase_tracker.sv
module sim_bus_phase_tracker;
  localparam int H = 16;
  logic clk2 = 1'b0, pwr_good = 1'b0;
  logic ads_n = 1'b1, na_n = 1'b1, rdy_n = 1'b1, mio = 1'b1, dc = 1'b1, wr = 1'b0, a1 = 1'b0, ucs_n = 1'b1;
  logic cpu_reset, phase2, xcvr_off, nmi;
  logic [2:0] bus_state;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  int es, ena, eseen, enmi;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk2 = ~clk2;

  bus_phase_tracker #(.HOLD_CYCLES(H)) u0 (
    .clk2(clk2), .pwr_good(pwr_good), .ads_n(ads_n), .na_n(na_n), .rdy_n(rdy_n),
    .mio(mio), .dc(dc), .wr(wr), .a1(a1), .ucs_n(ucs_n), .cpu_reset(cpu_reset),
    .phase2(phase2), .bus_state(bus_state), .xcvr_off(xcvr_off), .nmi(nmi));

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ads_n = 1'b1; na_n = 1'b1; rdy_n = 1'b1; mio = 1'b1; dc = 1'b1; wr = 1'b0; a1 = 1'b0; ucs_n = 1'b1;
  endtask

  task automatic do_reset(input string tag);
    idle_inputs();
    pwr_good = 1'b0;
    repeat (3) @(negedge clk2);
    check({tag, " R1 reset held"}, cpu_reset, 1);
    check({tag, " R2 phase during reset"}, phase2, 1);
    check({tag, " R10 state idle"}, bus_state, 0);
    check({tag, " R10 nmi low"}, nmi, 0);
    check({tag, " R10 xcvr_off low"}, xcvr_off, 0);
    pwr_good = 1'b1;
    for (int k = 1; k <= H + 2; k++) begin
      @(negedge clk2);
      if (k >= H) check({tag, " R1 reset length"}, cpu_reset, (k < H + 2) ? 1 : 0);
    end
    check({tag, " R2 phase at release"}, phase2, 1);
    es = 0; ena = 0; eseen = 0; enmi = 0;
  endtask

  task automatic step(input string tag, input bit a, input bit n, input bit r,
                      input bit sd, input bit hlt, input bit u);
    int nx;
    bit sdc;
    while (!phase2) @(negedge clk2);
    ads_n = ~a; na_n = ~n; rdy_n = ~r; ucs_n = ~u;
    if (sd || hlt) begin mio = 1'b1; dc = 1'b0; wr = 1'b1; a1 = hlt; end
    else begin mio = 1'b1; dc = 1'b1; wr = 1'b0; a1 = 1'b0; end
    nx = es;
    case (es)
      0: if (a) nx = 1;
      1, 3: nx = 2;
      2: if (r) nx = (a && ena != 0) ? 3 : 0;
         else if (a && ena != 0) nx = 4;
      4: if (r) nx = 3;
      default: nx = 0;
    endcase
    ena = (nx == 2) ? (((es == 2) && ena != 0) || n) : 0;
    sdc = a && sd && !hlt;
    if (sdc) enmi = 1; else if (u) enmi = 0;
    es = nx;
    if (es == 2 || es == 4) eseen = 1;
    @(negedge clk2);
    check({tag, " R3 R4 R5 R6 state"}, bus_state, es);
    check({tag, " R7 xcvr_off"}, xcvr_off, (eseen != 0 && (es == 0 || es == 1 || es == 3)) ? 1 : 0);
    check({tag, " R8 R9 nmi"}, nmi, enmi);
    check({tag, " R2 phase toggles"}, phase2, 0);
    ads_n = 1'b0; na_n = 1'b0; rdy_n = 1'b0; ucs_n = 1'b0; mio = 1'b1; dc = 1'b0; wr = 1'b1; a1 = 1'b0;
    @(negedge clk2);
    check({tag, " R2 off-phase state"}, bus_state, es);
    check({tag, " R2 off-phase nmi"}, nmi, enmi);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    do_reset("power-up");
    step("R3 start", 1, 0, 0, 0, 0, 0);
    step("R3 t1", 0, 0, 0, 0, 0, 0);
    step("R4 wait", 0, 0, 0, 0, 0, 0);
    step("R6 ads in t2 no na", 1, 0, 0, 0, 0, 0);
    step("R4 ready", 0, 0, 1, 0, 0, 0);
    step("R7 idle after data", 0, 0, 0, 0, 0, 0);
    step("R3 start2", 1, 0, 0, 0, 0, 0);
    step("R6 ads in t1", 1, 1, 0, 0, 0, 0);
    step("R5 t2p", 1, 0, 0, 0, 0, 0);
    step("R6 ads in t2p", 1, 0, 0, 0, 0, 0);
    step("R5 t1p", 0, 0, 1, 0, 0, 0);
    step("R5 t2 again", 0, 1, 0, 0, 0, 0);
    step("R5 direct t1p", 1, 0, 1, 0, 0, 0);
    step("R5 t2", 0, 0, 0, 0, 0, 0);
    step("R4 end", 0, 0, 1, 0, 0, 0);
    step("R8 halt", 1, 0, 0, 0, 1, 0);
    step("R8 halt t2", 0, 0, 1, 0, 0, 0);
    step("R8 shutdown", 1, 0, 0, 1, 0, 0);
    step("R9 hold", 0, 0, 1, 0, 0, 0);
    step("R9 clear", 0, 0, 0, 0, 0, 1);
    step("R9 collide", 1, 0, 0, 1, 0, 1);
    step("R9 collide t2", 0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("sweep", lfsr[0], lfsr[1], lfsr[2] | lfsr[3], lfsr[4] & lfsr[5] & lfsr[6],
           lfsr[7] & lfsr[8] & ~(lfsr[4] & lfsr[5] & lfsr[6]), lfsr[9] & lfsr[10] & lfsr[11]);
    end
    step("R10 setup", 1, 0, 0, 1, 0, 0);
    step("R10 setup t2", 0, 0, 0, 0, 0, 0);
    pwr_good = 1'b0;
    @(negedge clk2);
    check("R10 reset reasserted", cpu_reset, 1);
    do_reset("power-drop");
    step("R3 after drop", 1, 0, 0, 0, 0, 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk2);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule